// File: doc/BRIEF.md
# Multi-mode DMA channel sequencer

This block is the sequencer for one DMA channel. It carries data between an I/O peripheral and memory. Toward the peripheral it has a request input and an active-low acknowledge output. Toward the host it has a bus request and grant pair. While it owns the bus it puts a 24-bit address on it. The upper 8 bits come from a page value that is latched for the channel. The lower 16 bits come from the channel's current address counter. It also drives the four read and write strobes of the chosen direction, and a READY input can stretch them.

The channel is set up through a single configuration strobe. The strobe captures the transfer mode, the direction, the autoinitialize flag, the page, the start address and the count, and it unmasks the channel. Four modes decide when the bus is given back:

- **single:** after each transfer.
- **block:** when the count is used up.
- **demand:** when the request drops.
- **cascade:** the channel only acknowledges and leaves the bus to the peripheral until the request drops.

With autoinitialize set, the starting address and count come back on their own at terminal count. Without it, the channel masks itself.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the acknowledge output and all four strobes are high (inactive), bus request and terminal count are low, and the channel is masked.
- R2: While masked the channel ignores its request input: bus request stays low.
- R3: During a transfer the address output is {page[7:0], current address[15:0]}, and the page bits stay constant for the whole operation.
- R4: The lower address increments by one after each transfer and wraps from 0xFFFF to 0x0000 with no change to the page bits.
- R5: Mode 0 (single) performs exactly one transfer per bus grant, then drops the bus request even while the request input stays high.
- R6: Mode 1 (block) keeps transferring in one grant until terminal count, even if the request input falls after acknowledge.
- R7: Mode 2 (demand) releases the bus at the end of a transfer if the request input is low, keeps its address and count, and resumes from the next address on a later request.
- R8: Mode 3 (cascade) asserts only acknowledge on grant, with address enable low and all strobes high, and releases the bus once the request input is low.
- R9: With autoinitialize set, terminal count restores the start address and count and the channel stays unmasked and keeps serving requests.
- R10: The count is loaded as N-1 and N transfers take place. The terminal-count output pulses high for one cycle on the last one. Without autoinitialize the channel is then masked.
- R11: While READY is low, the active strobes and the address are held, one extra clock per low cycle.
- R12: Direction 0 (I/O to memory) drives the I/O read and memory write strobes low together. Direction 1 (memory to I/O) drives the memory read and I/O write strobes low together. No strobe is active outside acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_load | input | 1 | Capture configuration and unmask |
| cfg_mode | input | 2 | 0 single, 1 block, 2 demand, 3 cascade |
| cfg_dir | input | 1 | 0 I/O to memory, 1 memory to I/O |
| cfg_auto | input | 1 | Autoinitialize enable |
| cfg_page | input | 8 | Upper address bits |
| cfg_addr | input | 16 | Start address |
| cfg_cnt | input | 16 | Transfer count minus one |
| drq | input | 1 | Peripheral request |
| dack_n | output | 1 | Peripheral acknowledge, active low |
| hold_req | output | 1 | Bus request to host |
| hold_ack | input | 1 | Bus grant from host |
| ready | input | 1 | Low to stretch current transfer |
| addr_out | output | 24 | Bus address |
| addr_en | output | 1 | Address is driven by the channel |
| ior_n | output | 1 | I/O read strobe |
| iow_n | output | 1 | I/O write strobe |
| memr_n | output | 1 | Memory read strobe |
| memw_n | output | 1 | Memory write strobe |
| tc | output | 1 | Terminal-count pulse |

## Verification
The hardest case to reach is a demand-mode pause. The request has to fall in the exact cycle where one transfer has just ended and the next has not begun. Only then does the channel release the bus with its address and count partly used. The bench watches its transfer log after each clock edge. It drops the request as soon as the second transfer appears, which lands in that decision cycle. A later request must then resume at the third address. The wrap past 0xFFFF is reached by starting every swept job two addresses below it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    MD_SINGLE  = 2'd0,
    MD_BLOCK   = 2'd1,
    MD_DEMAND  = 2'd2,
    MD_CASCADE = 2'd3
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_XFER = 3'd2,
    ST_DONE = 3'd3,
    ST_CASC = 3'd4
  } seq_state_e;
endpackage

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dir,
  input  logic              cfg_auto,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              step,
  output xfer_mode_e        mode_q,
  output logic              dir_q,
  output logic              auto_q,
  output logic [PAGE_W-1:0] page_q,
  output logic [ADDR_W-1:0] cur_addr_q,
  output logic              cnt_zero,
  output logic              mask_q
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

  xfer_mode_e        mode_d;
  logic              dir_d, auto_d, mask_d;
  logic [PAGE_W-1:0] page_d;
  logic [ADDR_W-1:0] base_addr_q, base_addr_d, cur_addr_d;
  logic [CNT_W-1:0]  base_cnt_q, base_cnt_d, cur_cnt_q, cur_cnt_d;

  assign cnt_zero = (cur_cnt_q == '0);

  always_comb begin
    mode_d      = mode_q;
    dir_d       = dir_q;
    auto_d      = auto_q;
    page_d      = page_q;
    mask_d      = mask_q;
    base_addr_d = base_addr_q;
    base_cnt_d  = base_cnt_q;
    cur_addr_d  = cur_addr_q;
    cur_cnt_d   = cur_cnt_q;
    if (cfg_load) begin
      mode_d      = xfer_mode_e'(cfg_mode);
      dir_d       = cfg_dir;
      auto_d      = cfg_auto;
      page_d      = cfg_page;
      base_addr_d = cfg_addr;
      base_cnt_d  = cfg_cnt;
      cur_addr_d  = cfg_addr;
      cur_cnt_d   = cfg_cnt;
      mask_d      = 1'b0;
    end else if (step) begin
      cur_addr_d = cur_addr_q + ADDR_ONE;
      cur_cnt_d  = cur_cnt_q - CNT_ONE;
      if (cnt_zero) begin
        if (auto_q) begin
          cur_addr_d = base_addr_q;
          cur_cnt_d  = base_cnt_q;
        end else begin
          mask_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= MD_SINGLE;
      dir_q       <= 1'b0;
      auto_q      <= 1'b0;
      page_q      <= '0;
      mask_q      <= 1'b1;
      base_addr_q <= '0;
      base_cnt_q  <= '0;
      cur_addr_q  <= '0;
      cur_cnt_q   <= '0;
    end else begin
      mode_q      <= mode_d;
      dir_q       <= dir_d;
      auto_q      <= auto_d;
      page_q      <= page_d;
      mask_q      <= mask_d;
      base_addr_q <= base_addr_d;
      base_cnt_q  <= base_cnt_d;
      cur_addr_q  <= cur_addr_d;
      cur_cnt_q   <= cur_cnt_d;
    end
  end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
  import dma_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       drq,
  input  logic       hold_ack,
  input  logic       ready,
  input  logic       mask,
  input  xfer_mode_e mode,
  input  logic       cnt_zero,
  output seq_state_e state_q,
  output logic       step
);
  seq_state_e state_d;

  assign step = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (drq && !mask && !hold_ack) state_d = ST_REQ;
      ST_REQ:  if (hold_ack) state_d = (mode == MD_CASCADE) ? ST_CASC : ST_XFER;
      ST_XFER: if (ready) state_d = ST_DONE;
      ST_DONE: begin
        if (cnt_zero) begin
          state_d = ST_IDLE;
        end else begin
          unique case (mode)
            MD_BLOCK:  state_d = ST_XFER;
            MD_DEMAND: state_d = drq ? ST_XFER : ST_IDLE;
            default:   state_d = ST_IDLE;
          endcase
        end
      end
      ST_CASC: if (!drq) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end
endmodule

// File: rtl/dma_seq_bus.sv
module dma_seq_bus
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  seq_state_e        state,
  input  logic              dir,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] cur_addr,
  output logic              dack_n,
  output logic              hold_req,
  output logic              addr_en,
  output logic [BUS_W-1:0]  addr_out,
  output logic              ior_n,
  output logic              iow_n,
  output logic              memr_n,
  output logic              memw_n
);
  logic strobe_on;

  assign hold_req  = (state != ST_IDLE);
  assign dack_n    = !((state == ST_XFER) || (state == ST_DONE) || (state == ST_CASC));
  assign addr_en   = (state == ST_XFER) || (state == ST_DONE);
  assign addr_out  = {page, cur_addr};
  assign strobe_on = (state == ST_XFER);
  assign ior_n     = !(strobe_on && !dir);
  assign memw_n    = !(strobe_on && !dir);
  assign memr_n    = !(strobe_on && dir);
  assign iow_n     = !(strobe_on && dir);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  localparam int BUS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_dir,
  input  logic              cfg_auto,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CNT_W-1:0]  cfg_cnt,
  input  logic              drq,
  output logic              dack_n,
  output logic              hold_req,
  input  logic              hold_ack,
  input  logic              ready,
  output logic [BUS_W-1:0]  addr_out,
  output logic              addr_en,
  output logic              ior_n,
  output logic              iow_n,
  output logic              memr_n,
  output logic              memw_n,
  output logic              tc
);
  xfer_mode_e        mode_q;
  seq_state_e        state_q;
  logic              dir_q, auto_q, mask_q, cnt_zero, step;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] cur_addr_q;

  assign tc = step && cnt_zero;

  dma_seq_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_W(PAGE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_dir(cfg_dir), .cfg_auto(cfg_auto), .cfg_page(cfg_page),
    .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .step(step), .mode_q(mode_q),
    .dir_q(dir_q), .auto_q(auto_q), .page_q(page_q), .cur_addr_q(cur_addr_q),
    .cnt_zero(cnt_zero), .mask_q(mask_q)
  );

  dma_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .drq(drq), .hold_ack(hold_ack), .ready(ready),
    .mask(mask_q), .mode(mode_q), .cnt_zero(cnt_zero), .state_q(state_q),
    .step(step)
  );

  dma_seq_bus #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_bus (
    .state(state_q), .dir(dir_q), .page(page_q), .cur_addr(cur_addr_q),
    .dack_n(dack_n), .hold_req(hold_req), .addr_en(addr_en),
    .addr_out(addr_out), .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n),
    .memw_n(memw_n)
  );
endmodule

// File: rtl/dma_chan_seq_chk.sv
module dma_chan_seq_chk
  import dma_seq_pkg::*;
#(
  parameter int BUS_W  = 24,
  parameter int PAGE_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode_q,
  input logic             mask_q,
  input logic             dack_n,
  input logic             hold_req,
  input logic             ready,
  input logic [BUS_W-1:0] addr_out,
  input logic             addr_en,
  input logic             ior_n,
  input logic             iow_n,
  input logic             memr_n,
  input logic             memw_n,
  input logic             tc
);
  logic rd_on;
  assign rd_on = !ior_n || !memr_n;

  a_r12_one_pair: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({!ior_n, !memr_n}));

  a_r12_strobe_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (!ior_n || !iow_n || !memr_n || !memw_n) |-> !dack_n);

  a_r8_cascade_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MD_CASCADE && !dack_n) |-> (!addr_en && ior_n && iow_n && memr_n && memw_n));

  a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_en && $past(addr_en)) |-> (addr_out[BUS_W-1 -: PAGE_W] == $past(addr_out[BUS_W-1 -: PAGE_W])));

  a_r11_ready_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_on && !ready) |=> (rd_on && $stable(addr_out)));

  a_r2_masked_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q && !hold_req) |=> !hold_req);

  a_r10_tc_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> !tc);

  a_r10_tc_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> (!dack_n && addr_en));
endmodule

bind dma_chan_seq dma_chan_seq_chk #(.BUS_W(BUS_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .mask_q(mask_q), .dack_n(dack_n),
  .hold_req(hold_req), .ready(ready), .addr_out(addr_out), .addr_en(addr_en),
  .ior_n(ior_n), .iow_n(iow_n), .memr_n(memr_n), .memw_n(memw_n), .tc(tc)
);

// File: tb/dma_chan_seq_tb.sv
module dma_chan_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOG_N = 64;

  logic        clk, rst_n, cfg_load, cfg_dir, cfg_auto, drq, hold_ack, ready;
  logic [1:0]  cfg_mode;
  logic [7:0]  cfg_page;
  logic [15:0] cfg_addr, cfg_cnt;
  logic        dack_n, hold_req, addr_en, ior_n, iow_n, memr_n, memw_n, tc;
  logic [23:0] addr_out;

  int total, bad, cyc;
  int nlog, ntc, spans, max_span, cur_span, pair_bad;
  logic [15:0] log_addr [LOG_N];
  logic [7:0]  log_page [LOG_N];
  logic        log_dir  [LOG_N];
  logic        prev_dack_n;

  dma_chan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_dir(cfg_dir), .cfg_auto(cfg_auto), .cfg_page(cfg_page),
    .cfg_addr(cfg_addr), .cfg_cnt(cfg_cnt), .drq(drq), .dack_n(dack_n),
    .hold_req(hold_req), .hold_ack(hold_ack), .ready(ready),
    .addr_out(addr_out), .addr_en(addr_en), .ior_n(ior_n), .iow_n(iow_n),
    .memr_n(memr_n), .memw_n(memw_n), .tc(tc)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // host grants the bus one cycle after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_ack <= 1'b0;
    else        hold_ack <= hold_req;
  end

  // transfer monitor, sampled on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (addr_en && (!ior_n || !memr_n) && ready) begin
        if (nlog < LOG_N) begin
          log_addr[nlog] = addr_out[15:0];
          log_page[nlog] = addr_out[23:16];
          log_dir[nlog]  = !memr_n;
        end
        nlog++;
        cur_span++;
      end
      if (!ior_n && (memw_n || !iow_n || !memr_n)) pair_bad++;
      if (!memr_n && (iow_n || !memw_n || !ior_n)) pair_bad++;
      if (tc) ntc++;
      if (dack_n && !prev_dack_n) begin
        spans++;
        if (cur_span > max_span) max_span = cur_span;
        cur_span = 0;
      end
      prev_dack_n = dack_n;
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    nlog = 0; ntc = 0; spans = 0; max_span = 0; cur_span = 0; pair_bad = 0;
  endtask

  task automatic do_cfg(input logic [1:0] m, input logic d, input logic a,
                        input logic [7:0] pg, input logic [15:0] ad, input int n);
    cfg_mode = m; cfg_dir = d; cfg_auto = a; cfg_page = pg; cfg_addr = ad;
    cfg_cnt = 16'(n - 1);
    cfg_load = 1'b1;
    tick();
    cfg_load = 1'b0;
  endtask

  task automatic wait_tc(input int want);
    for (int i = 0; i < 400 && ntc < want; i++) tick();
    chk(ntc >= want, "R10 terminal count reached", ntc, want);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 100000, 0);
    finish_run();
  end

  initial begin
    total = 0; bad = 0; cyc = 0; prev_dack_n = 1'b1;
    clear_log();
    rst_n = 1'b0; cfg_load = 1'b0; cfg_mode = 2'd0; cfg_dir = 1'b0;
    cfg_auto = 1'b0; cfg_page = 8'h0; cfg_addr = 16'h0; cfg_cnt = 16'h0;
    drq = 1'b0; ready = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk(dack_n && ior_n && iow_n && memr_n && memw_n && !hold_req && !tc,
        "R1 reset outputs", {dack_n, ior_n, iow_n, memr_n, memw_n, hold_req, tc}, 7'b1111100);

    // R2: masked after reset, request ignored
    drq = 1'b1;
    repeat (8) tick();
    chk(!hold_req && nlog == 0, "R2 masked ignores drq", hold_req, 0);
    drq = 1'b0;
    tick();

    // sweep: modes single/block/demand, both directions, several counts across the wrap
    for (int m = 0; m < 3; m++) begin
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 4; k++) begin
          automatic int n = (k == 3) ? 5 : k + 1;
          automatic logic [7:0] pg = 8'(8'h40 + m * 16 + d * 8 + n);
          automatic logic [15:0] st = 16'hFFFE;
          clear_log();
          do_cfg(2'(m), 1'(d), 1'b0, pg, st, n);
          drq = 1'b1;
          if (m == 1) begin
            for (int i = 0; i < 20 && dack_n; i++) tick();
            drq = 1'b0; // R6: block keeps going without drq
          end
          wait_tc(1);
          repeat (4) tick();
          chk(nlog == n, "R10 transfer count", nlog, n);
          for (int i = 0; i < n; i++) begin
            chk(log_addr[i] == 16'(st + 16'(i)), "R4 address sequence with wrap", log_addr[i], 16'(st + 16'(i)));
            chk(log_page[i] == pg, "R3 page bits", log_page[i], pg);
            chk(log_dir[i] == 1'(d), "R12 strobe direction", log_dir[i], d);
          end
          chk(pair_bad == 0, "R12 strobe pairing", pair_bad, 0);
          if (m == 0) begin
            chk(spans == n && max_span == 1, "R5 one transfer per grant", max_span, 1);
          end else begin
            chk(spans == 1, "R6 R7 single grant for whole job", spans, 1);
          end
          chk(ntc == 1, "R10 tc pulse count", ntc, 1);
          // R10: masked after terminal count
          drq = 1'b1;
          repeat (6) tick();
          chk(!hold_req && nlog == n, "R10 masked after tc", nlog, n);
          drq = 1'b0;
          tick();
        end
      end
    end

    // R7: demand pause and resume
    clear_log();
    do_cfg(2'd2, 1'b0, 1'b0, 8'h12, 16'h0100, 6);
    drq = 1'b1;
    for (int i = 0; i < 50 && nlog < 2; i++) tick();
    drq = 1'b0;
    repeat (5) tick();
    chk(nlog == 2 && !hold_req && dack_n, "R7 demand pauses", nlog, 2);
    drq = 1'b1;
    wait_tc(1);
    drq = 1'b0;
    repeat (3) tick();
    chk(nlog == 6 && spans == 2, "R7 demand resumes", nlog, 6);
    chk(log_addr[2] == 16'h0102 && log_addr[5] == 16'h0105, "R7 resume address", log_addr[2], 16'h0102);

    // R11: READY stretches the transfer
    clear_log();
    ready = 1'b0;
    do_cfg(2'd0, 1'b1, 1'b0, 8'h33, 16'h0500, 1);
    drq = 1'b1;
    for (int i = 0; i < 20 && memr_n; i++) tick();
    for (int i = 0; i < 3; i++) begin
      chk(!memr_n && !iow_n && nlog == 0 && addr_out == 24'h330500, "R11 held while not ready", memr_n, 0);
      tick();
    end
    ready = 1'b1;
    tick();
    chk(memr_n && iow_n && nlog == 1, "R11 completes after ready", nlog, 1);
    drq = 1'b0;
    repeat (4) tick();

    // R8: cascade
    clear_log();
    do_cfg(2'd3, 1'b0, 1'b0, 8'h55, 16'h0700, 4);
    drq = 1'b1;
    for (int i = 0; i < 20 && dack_n; i++) tick();
    for (int i = 0; i < 4; i++) begin
      chk(!dack_n && !addr_en && ior_n && iow_n && memr_n && memw_n, "R8 cascade only acknowledges",
          {dack_n, addr_en, ior_n, iow_n, memr_n, memw_n}, 6'b001111);
      tick();
    end
    drq = 1'b0;
    tick();
    chk(dack_n && !hold_req && nlog == 0 && ntc == 0, "R8 cascade releases", dack_n, 1);

    // R9: autoinitialize in block mode
    clear_log();
    do_cfg(2'd1, 1'b0, 1'b1, 8'h77, 16'h2000, 3);
    drq = 1'b1;
    for (int i = 0; i < 200 && nlog < 6; i++) tick();
    drq = 1'b0;
    repeat (4) tick();
    chk(ntc == 2 && nlog == 6, "R9 two terminal counts", ntc, 2);
    for (int i = 0; i < 6; i++)
      chk(log_addr[i] == 16'(16'h2000 + 16'(i % 3)), "R9 reload address", log_addr[i], 16'(16'h2000 + 16'(i % 3)));
    drq = 1'b1;
    for (int i = 0; i < 10 && dack_n; i++) tick();
    chk(!dack_n, "R9 still unmasked", dack_n, 0);
    drq = 1'b0;
    wait_tc(3);
    repeat (3) tick();
    chk(log_addr[6] == 16'h2000, "R9 restart at base", log_addr[6], 16'h2000);

    finish_run();
  end
endmodule